// File: doc/BRIEF.md
# Bit-Serial Handshake Link Controller

This block joins a host to a remote node over a full-duplex serial link that moves one bit at a time. Each direction carries a data line, a bit strobe from the sender, a ready-for-next-bit line from the receiver and a final-bit marker. A bit moves in four phases. The receiver raises its ready line. The sender drives the data and raises the strobe. The receiver drops ready once it has taken the bit. The sender then drops the strobe. The two directions run on their own, and every input from the remote is passed through two flip-flop stages before the controller reacts to it.

The host sees three registers. The first is a write-only transmit holding register with a last-byte flag. The second is a receive holding register with a read strobe. The third is a small control register that holds transmit enable, receive enable and a bit that selects interrupt or polled completion. Each side drives its own ready line. The host sets or clears its line with two pulse inputs. A remote line that is low aborts any transfer in progress and holds every attention output high. The remote end works only in 16-bit words, so the last-byte flag is honoured only on a byte that completes a word.

Top module: `bitlink_top`

## Requirements
- R1: While reset is held, `txl_valid`, `txl_final`, `rxl_ready`, `host_up` and `rx_last_seen` are all low.
- R2: `txl_valid` rises only after the synchronised `txl_ready` has been seen high. It falls only after `txl_ready` has been seen low, or on an abort. `txl_bit` does not change while `txl_valid` stays high.
- R3: A write on `tx_wr` is taken only when control bit 0 is set, no byte is in flight and the peer is up. Otherwise it is ignored. A taken byte is sent most significant bit first.
- R4: `txl_final` is high together with the strobe of bit 7 of a byte written with `tx_wlast`. This happens only when that byte is the second byte of a 16-bit word, counted from reset, from an abort or from the last honoured flag. On a first byte the flag is dropped.
- R5: `rxl_ready` is high only when control bit 1 is set, no unread byte is held and the peer is up. It drops after a strobe is seen and rises again only after the strobe has been seen low.
- R6: Received bits are shifted in with the first bit ending up as the most significant. A byte completes after 8 bits, or earlier on a bit sent with `rxl_final`. A short byte is right-aligned with zeros above it, and `rx_last_seen` is then set.
- R7: A pulse on `rx_rd` clears the held byte's attention and `rx_last_seen`.
- R8: `host_set_rdy` raises `host_up` and `host_set_nrdy` lowers it. If both pulse together, the clear wins. `host_down` always shows the inverse of `host_up`.
- R9: `tx_attn` is high when transmit is enabled and idle. `rx_attn` is high when an unread byte is held. While `peer_up` is low, both stay high without a break and `remote_down` is high. `check_flag` is `remote_down` OR `rx_last_seen`.
- R10: `tx_irq` and `rx_irq` follow `tx_attn` and `rx_attn` when control bit 2 is set, and stay low when it is clear.
- R11: When `peer_up` falls, a byte in flight is dropped and the strobe falls. Partial receive bits are discarded, and the byte is not resent when the peer comes back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | {irq mode, rx enable, tx enable} |
| tx_wr | input | 1 | Transmit holding register write |
| tx_wdata | input | 8 | Byte to send |
| tx_wlast | input | 1 | Byte ends the message |
| host_set_rdy | input | 1 | Pulse: raise host ready line |
| host_set_nrdy | input | 1 | Pulse: lower host ready line |
| rx_rd | input | 1 | Receive holding register read pulse |
| rx_rdata | output | 8 | Received byte |
| rx_last_seen | output | 1 | Held byte ended with the final bit |
| remote_down | output | 1 | Peer ready line is low |
| host_down | output | 1 | Host ready line is low |
| check_flag | output | 1 | remote_down OR rx_last_seen |
| tx_attn | output | 1 | Transmit needs service |
| rx_attn | output | 1 | Receive needs service |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |
| txl_bit | output | 1 | Outgoing data bit |
| txl_valid | output | 1 | Outgoing bit strobe |
| txl_final | output | 1 | Outgoing final-bit marker |
| txl_ready | input | 1 | Peer ready for next bit |
| rxl_bit | input | 1 | Incoming data bit |
| rxl_valid | input | 1 | Incoming bit strobe |
| rxl_final | input | 1 | Incoming final-bit marker |
| rxl_ready | output | 1 | Ready for next incoming bit |
| host_up | output | 1 | Host ready line to peer |
| peer_up | input | 1 | Peer ready line |

## Verification
The bench builds the block with its defaults: 8-bit bytes and two synchroniser stages. With only 256 byte values, every one of them is sent through the transmitter and every one is received, and the bench assembles each byte and recomputes it bit by bit as it plays the peer. The narrow word size also makes the word-parity rule for the final marker cheap to drive: a dropped flag on a first byte, an honoured flag on a second byte, and a short received byte ended by the marker. Peer loss is applied both between bytes and in the middle of a strobe.

// File: rtl/bitlink_pkg.sv
package bitlink_pkg;

  typedef enum logic {
    TX_WAIT_RDY,
    TX_WAIT_DROP
  } tx_state_t;

  typedef enum logic {
    RX_WAIT_STRB,
    RX_WAIT_CLR
  } rx_state_t;

  // A last-byte request is honoured only when the byte closes a 16-bit word.
  function automatic logic honour_last(input logic want, input logic odd_seen);
    return want & odd_seen;
  endfunction

endpackage

// File: rtl/bitlink_sync.sv
module bitlink_sync #(
  parameter int W = 1,
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < N; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[N-1];
endmodule

// File: rtl/bitlink_tx.sv
module bitlink_tx
  import bitlink_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          abort,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          wlast,
  input  logic          ready_s,
  output logic          bit_o,
  output logic          valid_o,
  output logic          final_o,
  output logic          busy_o
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(DW - 1);

  tx_state_t     st;
  logic [DW-1:0] sh;
  logic [CW-1:0] cnt;
  logic          busy, mark, odd, valid;
  logic          accept, bit_done;

  assign accept   = en && !busy && wr;
  assign bit_done = (st == TX_WAIT_DROP) && !ready_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= TX_WAIT_RDY; sh <= '0; cnt <= '0;
      busy <= 1'b0; mark <= 1'b0; odd <= 1'b0; valid <= 1'b0;
    end else if (abort) begin
      st <= TX_WAIT_RDY; cnt <= '0;
      busy <= 1'b0; odd <= 1'b0; valid <= 1'b0;
    end else begin
      if (accept) begin
        sh   <= wdata;
        busy <= 1'b1;
        mark <= honour_last(wlast, odd);
        odd  <= ~odd;
      end
      case (st)
        TX_WAIT_RDY: if (busy && ready_s) begin
          valid <= 1'b1;
          st    <= TX_WAIT_DROP;
        end
        TX_WAIT_DROP: if (bit_done) begin
          valid <= 1'b0;
          st    <= TX_WAIT_RDY;
          if (cnt == LAST_IDX) begin
            busy <= 1'b0;
            cnt  <= '0;
          end else begin
            cnt <= cnt + CW'(1);
            sh  <= sh << 1;
          end
        end
        default: st <= TX_WAIT_RDY;
      endcase
    end
  end

  assign bit_o   = sh[DW-1];
  assign valid_o = valid;
  assign final_o = valid && mark && (cnt == LAST_IDX);
  assign busy_o  = busy;

  p_strobe_after_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(ready_s));
  p_strobe_drop_after_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid_o) |-> (!$past(ready_s) || $past(abort)));
  p_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(valid_o)) |-> $stable(bit_o));
  p_final_with_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    final_o |-> valid_o);
endmodule

// File: rtl/bitlink_rx.sv
module bitlink_rx
  import bitlink_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          abort,
  input  logic          rd,
  input  logic          bit_s,
  input  logic          valid_s,
  input  logic          final_s,
  output logic          ready_o,
  output logic [DW-1:0] data_o,
  output logic          full_o,
  output logic          last_o
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DW);

  rx_state_t     st;
  logic [DW-1:0] sh;
  logic [CW-1:0] cnt;
  logic          rdy, full, lastb, last_st;
  logic          take, byte_end;

  function automatic logic [DW-1:0] push_bit(input logic [DW-1:0] cur,
                                             input logic first, input logic b);
    logic [DW-1:0] base;
    base = first ? '0 : cur;
    return {base[DW-2:0], b};
  endfunction

  assign take     = (st == RX_WAIT_STRB) && rdy && valid_s;
  assign byte_end = (st == RX_WAIT_CLR) && !valid_s && ((cnt == FULL_CNT) || lastb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RX_WAIT_STRB; sh <= '0; cnt <= '0;
      rdy <= 1'b0; full <= 1'b0; lastb <= 1'b0; last_st <= 1'b0;
    end else begin
      if (rd) begin
        full    <= 1'b0;
        last_st <= 1'b0;
      end
      if (abort) begin
        rdy <= 1'b0;
        cnt <= '0;
        st  <= RX_WAIT_STRB;
      end else begin
        case (st)
          RX_WAIT_STRB: begin
            if (take) begin
              sh    <= push_bit(sh, cnt == '0, bit_s);
              cnt   <= cnt + CW'(1);
              lastb <= final_s;
              rdy   <= 1'b0;
              st    <= RX_WAIT_CLR;
            end else begin
              rdy <= en && !full;
            end
          end
          RX_WAIT_CLR: if (!valid_s) begin
            st <= RX_WAIT_STRB;
            if (byte_end) begin
              full    <= 1'b1;
              last_st <= lastb;
              cnt     <= '0;
            end
          end
          default: st <= RX_WAIT_STRB;
        endcase
      end
    end
  end

  assign ready_o = rdy;
  assign data_o  = sh;
  assign full_o  = full;
  assign last_o  = last_st;

  p_no_ready_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !ready_o);
  p_count_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);
  p_ready_drop_on_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_o) |-> ($past(valid_s) || $past(abort) || !$past(en) || $past(full_o)));
endmodule

// File: rtl/bitlink_top.sv
module bitlink_top #(
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [2:0]        ctl_wdata,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              tx_wlast,
  input  logic              host_set_rdy,
  input  logic              host_set_nrdy,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_rdata,
  output logic              rx_last_seen,
  output logic              remote_down,
  output logic              host_down,
  output logic              check_flag,
  output logic              tx_attn,
  output logic              rx_attn,
  output logic              tx_irq,
  output logic              rx_irq,
  output logic              txl_bit,
  output logic              txl_valid,
  output logic              txl_final,
  input  logic              txl_ready,
  input  logic              rxl_bit,
  input  logic              rxl_valid,
  input  logic              rxl_final,
  output logic              rxl_ready,
  output logic              host_up,
  input  logic              peer_up
);
  localparam int NSYNC = 5;

  logic [2:0]       ctl_q;
  logic             host_up_q;
  logic [NSYNC-1:0] async_in, sync_out;
  logic             txr_s, rxb_s, rxv_s, rxf_s, peer_s;
  logic             peer_lost, tx_busy, rx_full;

  assign async_in = {txl_ready, rxl_bit, rxl_valid, rxl_final, peer_up};

  bitlink_sync #(.W(NSYNC), .N(SYNC_N)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(async_in), .q(sync_out)
  );

  assign {txr_s, rxb_s, rxv_s, rxf_s, peer_s} = sync_out;
  assign peer_lost = !peer_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      host_up_q <= 1'b0;
    end else begin
      if (ctl_we) ctl_q <= ctl_wdata;
      if (host_set_nrdy)     host_up_q <= 1'b0;
      else if (host_set_rdy) host_up_q <= 1'b1;
    end
  end

  bitlink_tx #(.DW(DATA_W)) tx_i (
    .clk(clk), .rst_n(rst_n), .en(ctl_q[0]), .abort(peer_lost),
    .wr(tx_wr), .wdata(tx_wdata), .wlast(tx_wlast), .ready_s(txr_s),
    .bit_o(txl_bit), .valid_o(txl_valid), .final_o(txl_final), .busy_o(tx_busy)
  );

  bitlink_rx #(.DW(DATA_W)) rx_i (
    .clk(clk), .rst_n(rst_n), .en(ctl_q[1]), .abort(peer_lost), .rd(rx_rd),
    .bit_s(rxb_s), .valid_s(rxv_s), .final_s(rxf_s),
    .ready_o(rxl_ready), .data_o(rx_rdata), .full_o(rx_full), .last_o(rx_last_seen)
  );

  assign tx_attn     = (ctl_q[0] && !tx_busy) || peer_lost;
  assign rx_attn     = rx_full || peer_lost;
  assign tx_irq      = ctl_q[2] && tx_attn;
  assign rx_irq      = ctl_q[2] && rx_attn;
  assign remote_down = peer_lost;
  assign host_up     = host_up_q;
  assign host_down   = !host_up_q;
  assign check_flag  = peer_lost || rx_last_seen;

  p_irq_needs_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq || rx_irq) |-> ctl_q[2]);
  p_peer_loss_holds_attn_r9: assert property (@(posedge clk) disable iff (!rst_n)
    remote_down |-> (tx_irq == ctl_q[2]) && (rx_irq == ctl_q[2]));
  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(host_set_nrdy) |-> !host_up);
  p_abort_quiets_link_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(peer_lost) |-> (!txl_valid && !rxl_ready));
endmodule

// File: tb/bitlink_top_tb_top.sv
module bitlink_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 0; logic [2:0] ctl_wdata = '0;
  logic tx_wr = 0; logic [7:0] tx_wdata = '0; logic tx_wlast = 0;
  logic host_set_rdy = 0, host_set_nrdy = 0, rx_rd = 0;
  logic [7:0] rx_rdata;
  logic rx_last_seen, remote_down, host_down, check_flag;
  logic tx_attn, rx_attn, tx_irq, rx_irq;
  logic txl_bit, txl_valid, txl_final, rxl_ready, host_up;
  logic txl_ready = 0, rxl_bit = 0, rxl_valid = 0, rxl_final = 0, peer_up = 0;

  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitlink_top dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_wlast(tx_wlast),
    .host_set_rdy(host_set_rdy), .host_set_nrdy(host_set_nrdy), .rx_rd(rx_rd),
    .rx_rdata(rx_rdata), .rx_last_seen(rx_last_seen), .remote_down(remote_down),
    .host_down(host_down), .check_flag(check_flag), .tx_attn(tx_attn),
    .rx_attn(rx_attn), .tx_irq(tx_irq), .rx_irq(rx_irq),
    .txl_bit(txl_bit), .txl_valid(txl_valid), .txl_final(txl_final),
    .txl_ready(txl_ready), .rxl_bit(rxl_bit), .rxl_valid(rxl_valid),
    .rxl_final(rxl_final), .rxl_ready(rxl_ready), .host_up(host_up), .peer_up(peer_up)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ctl(input logic [2:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic write_tx(input logic [7:0] v, input logic last);
    @(negedge clk); tx_wr = 1; tx_wdata = v; tx_wlast = last;
    @(negedge clk); tx_wr = 0; tx_wlast = 0;
  endtask

  // Peer side receiving from the block: assembles MSB first.
  task automatic take_byte(output logic [7:0] b, output logic [7:0] fin);
    b = '0; fin = '0;
    for (int i = 0; i < 8; i++) begin
      int w;
      txl_ready = 1; w = 0;
      while (!txl_valid && w < TMO) begin @(negedge clk); w++; end
      if (w >= TMO) chk(0, "R2 strobe timeout", 0, 1);
      b = {b[6:0], txl_bit};
      fin[7-i] = txl_final;
      txl_ready = 0; w = 0;
      while (txl_valid && w < TMO) begin @(negedge clk); w++; end
      if (w >= TMO) chk(0, "R2 strobe release timeout", 1, 0);
    end
  endtask

  // Peer side sending to the block: first bit sent is v[n-1].
  task automatic send_bits(input logic [7:0] v, input int n, input bit fin);
    for (int i = 0; i < n; i++) begin
      int w;
      w = 0;
      while (!rxl_ready && w < TMO) begin @(negedge clk); w++; end
      if (w >= TMO) chk(0, "R5 ready timeout", 0, 1);
      rxl_bit = v[n-1-i];
      rxl_final = fin && (i == n-1);
      @(negedge clk); rxl_valid = 1;
      w = 0;
      while (rxl_ready && w < TMO) begin @(negedge clk); w++; end
      if (w >= TMO) chk(0, "R5 ready drop timeout", 1, 0);
      rxl_valid = 0; rxl_final = 0;
      @(negedge clk);
    end
  endtask

  task automatic wait_rx_attn();
    int w;
    w = 0;
    while (!rx_attn && w < 40) begin @(negedge clk); w++; end
  endtask

  task automatic expect_silence(input string req);
    bit seen;
    seen = 0;
    txl_ready = 1;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (txl_valid) seen = 1; end
    txl_ready = 0;
    cycles(4);
    chk(!seen, req, seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] b, fin;
    cycles(3);
    // R1 reset state
    chk(!txl_valid && !txl_final, "R1 tx link idle in reset", txl_valid, 0);
    chk(!rxl_ready, "R1 rx ready low in reset", rxl_ready, 0);
    chk(!host_up && !rx_last_seen, "R1 host_up/last low in reset", host_up, 0);
    rst_n = 1; peer_up = 1;
    cycles(6);
    chk(!remote_down, "R9 peer up seen", remote_down, 0);

    // R8 host ready pulses
    @(negedge clk); host_set_rdy = 1; @(negedge clk); host_set_rdy = 0;
    chk(host_up && !host_down, "R8 set ready", host_up, 1);
    @(negedge clk); host_set_nrdy = 1; @(negedge clk); host_set_nrdy = 0;
    chk(!host_up && host_down, "R8 set not ready", host_up, 0);
    @(negedge clk); host_set_rdy = 1; @(negedge clk); host_set_rdy = 0;
    @(negedge clk); host_set_rdy = 1; host_set_nrdy = 1;
    @(negedge clk); host_set_rdy = 0; host_set_nrdy = 0;
    chk(!host_up, "R8 clear wins", host_up, 0);

    // R3 write ignored while disabled; R9 attention low when disabled
    chk(!tx_attn, "R9 tx attn low when disabled", tx_attn, 0);
    write_tx(8'hA5, 0);
    expect_silence("R3 write while disabled ignored");

    // R3 sweep of every byte value, MSB first
    set_ctl(3'b001);
    chk(tx_attn, "R9 tx attn when enabled idle", tx_attn, 1);
    for (int v = 0; v < 256; v++) begin
      write_tx(8'(v), 0);
      if (v == 0) chk(!tx_attn, "R9 tx attn low while busy", tx_attn, 0);
      take_byte(b, fin);
      chk(b == 8'(v), "R3 byte serialised MSB first", b, v);
      chk(fin == 8'h00, "R4 no final without flag", fin, 0);
    end
    cycles(3);
    chk(tx_attn, "R9 tx attn back after byte", tx_attn, 1);

    // R4 word-parity rule for the final marker
    write_tx(8'h3C, 1); take_byte(b, fin);
    chk(fin == 8'h00, "R4 flag on first byte dropped", fin, 0);
    write_tx(8'hC3, 1); take_byte(b, fin);
    chk(b == 8'hC3, "R3 second byte data", b, 8'hC3);
    chk(fin == 8'h01, "R4 final on bit 7 of second byte", fin, 1);
    write_tx(8'h11, 0); take_byte(b, fin);
    write_tx(8'h22, 1); take_byte(b, fin);
    chk(fin == 8'h01 && b == 8'h22, "R4 honoured after new word", fin, 1);

    // R3 write while busy ignored
    write_tx(8'h5A, 0);
    write_tx(8'hFF, 0);
    take_byte(b, fin);
    chk(b == 8'h5A, "R3 first byte kept", b, 8'h5A);
    expect_silence("R3 write while busy ignored");

    // R11 abort mid-strobe
    write_tx(8'h96, 0);
    txl_ready = 1;
    begin
      int w;
      w = 0;
      while (!txl_valid && w < TMO) begin @(negedge clk); w++; end
    end
    peer_up = 0;
    cycles(5);
    chk(!txl_valid, "R11 strobe dropped on peer loss", txl_valid, 0);
    txl_ready = 0;
    begin
      bit gap;
      gap = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (!(tx_attn && rx_attn && remote_down && check_flag)) gap = 1;
      end
      chk(!gap, "R9 attention held while peer down", gap, 0);
    end
    chk(!tx_irq, "R10 no irq in polled mode", tx_irq, 0);
    peer_up = 1;
    cycles(6);
    expect_silence("R11 aborted byte not resent");

    // R5/R6/R7 receive sweep
    set_ctl(3'b010);
    cycles(4);
    chk(rxl_ready, "R5 ready when enabled", rxl_ready, 1);
    for (int v = 0; v < 256; v++) begin
      send_bits(8'(v), 8, 0);
      wait_rx_attn();
      chk(rx_attn && rx_rdata == 8'(v), "R6 byte assembled", rx_rdata, v);
      chk(!rx_last_seen, "R6 no last flag", rx_last_seen, 0);
      cycles(3);
      chk(!rxl_ready, "R5 ready held low while full", rxl_ready, 0);
      if (v == 0) chk(!rx_irq, "R10 rx irq low in polled mode", rx_irq, 0);
      @(negedge clk); rx_rd = 1; @(negedge clk); rx_rd = 0;
      chk(!rx_attn, "R7 read clears attention", rx_attn, 1);
    end

    // R6 short byte ended by final bit
    send_bits(8'b0000_0101, 3, 1);
    wait_rx_attn();
    chk(rx_rdata == 8'h05, "R6 short byte right-aligned", rx_rdata, 5);
    chk(rx_last_seen && check_flag, "R6 R9 last bit flags", rx_last_seen, 1);
    set_ctl(3'b110);
    chk(rx_irq && !tx_irq, "R10 rx irq in interrupt mode", rx_irq, 1);
    @(negedge clk); rx_rd = 1; @(negedge clk); rx_rd = 0;
    chk(!rx_last_seen && !check_flag && !rx_irq, "R7 read clears last flag", rx_last_seen, 0);

    // R10 peer loss raises both irqs in interrupt mode
    peer_up = 0;
    cycles(5);
    chk(tx_irq && rx_irq, "R10 irq on peer loss", tx_irq, 1);
    peer_up = 1;
    cycles(5);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule